// File: doc/BRIEF.md
# Switchable Fixed-Priority / Round-Robin Arbiter

This block decides which of 2 to 4 masters may use one shared slave port of an interconnect. Each master raises a request line and presents a 3-bit priority level. The arbiter answers with a registered one-hot grant. A granted master keeps the port until it lowers its request.

One 32-bit configuration word selects how the winner is chosen. Its top bit picks either a fixed-priority scheme or a rotating (round-robin) scheme. The three bits below it give the level where the rotation begins. Software writes the word through a plain write-enable port and can read the live value back at any time.

Top module: `cfg_arbiter`

## Requirements
- R1: After reset, every grant is low and the configuration word reads 0x0000_0000, which means fixed-priority mode with a starting level of 0.
- R2: Bit 31 of the configuration word selects the policy (0 = fixed priority, 1 = round robin). Bits 31:28 read back the value of the last write.
- R3: In fixed mode the grant goes to the requesting master with the numerically smallest level, where level 0 is the most urgent. The level of master k is lvl_i[3k+2:3k].
- R4: In fixed mode, when requesting masters share the best level, the one with the lowest index wins.
- R5: In round-robin mode the search starts at the pointer and walks up through the indices, wrapping past N_MST-1 to 0. After each grant the pointer moves to the index just after the granted master.
- R6: A write to the configuration word loads the pointer with bits 30:28 modulo N_MST, and reset loads 0. When a write and a new round-robin grant fall in the same cycle, the written value wins over the advance.
- R7: While fixed mode is selected, the starting-level field has no effect on which master is granted.
- R8: At most one grant is high in any cycle.
- R9: A master that was chosen by an idle arbiter sees its grant one clock after its request. The grant stays high while the request stays high. In the cycle its request is low, a new decision is made and shows one clock later.
- R10: With no request pending, no grant is given and the round-robin pointer does not move.
- R11: Bits 27:0 of the configuration word always read zero and ignore writes.
- R12: A configuration write takes effect for decisions from the next clock on. It never removes or moves a grant that is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Request line, one per master |
| lvl_i | input | 3*N_MST | Priority level of each master, 3 bits per master |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Current configuration word |
| gnt_o | output | N_MST | One-hot grant, one per master |

## Verification
A configuration write can land in the same cycle in which the round-robin scheme hands out a fresh grant, so the pointer gets both a load and an advance. The bench provokes this by raising all requests in the very cycle a new starting level is written. It then checks two things. First, the grant given in that cycle follows the old pointer. Second, the grant that follows once the winner drops its request comes from the written level and not from the advanced pointer. A second overlap, a policy write while a grant is held, is judged by checking that the grant does not move until its request falls.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int CFG_W     = 32;
    localparam int POL_BIT   = 31;
    localparam int START_MSB = 30;
    localparam int START_LSB = 28;
    localparam int START_W   = START_MSB - START_LSB + 1;
    localparam int LVL_W     = 3;

    typedef struct packed {
        logic               rr;
        logic [START_W-1:0] start;
    } arb_cfg_t;

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
    import arb_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [CFG_W-1:0]   wdata_i,
    output arb_cfg_t           cfg_o,
    output logic               start_load_o,
    output logic [CFG_W-1:0]   rdata_o
);

    arb_cfg_t cfg_d, cfg_q;
    logic     unused_low_bits;

    assign unused_low_bits = ^wdata_i[START_LSB-1:0];

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.rr    = wdata_i[POL_BIT];
            cfg_d.start = wdata_i[START_MSB:START_LSB];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o        = cfg_q;
    assign start_load_o = we_i;
    assign rdata_o      = {cfg_q.rr, cfg_q.start, {START_LSB{1'b0}}};

endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick
    import arb_pkg::*;
#(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0]       req_i,
    input  logic [N_MST*LVL_W-1:0] lvl_i,
    output logic                   vld_o,
    output logic [IDX_W-1:0]       idx_o
);

    logic [LVL_W-1:0] lvl_of [N_MST];
    logic [LVL_W-1:0] best;

    for (genvar g = 0; g < N_MST; g++) begin : g_slice
        assign lvl_of[g] = lvl_i[g*LVL_W +: LVL_W];
    end

    // Strict comparison keeps the earliest (lowest index) master on a tie.
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        best  = '1;
        for (int k = 0; k < N_MST; k++) begin
            if (req_i[k] && (!vld_o || (lvl_of[k] < best))) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(k);
                best  = lvl_of[k];
            end
        end
    end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);

    int unsigned pos;

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        pos   = 0;
        for (int off = 0; off < N_MST; off++) begin
            pos = (int'(ptr_i) + off) % N_MST;
            if (!vld_o && req_i[pos]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/cfg_arbiter.sv
module cfg_arbiter
    import arb_pkg::*;
#(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [N_MST-1:0]       req_i,
    input  logic [N_MST*LVL_W-1:0] lvl_i,
    input  logic                   cfg_we_i,
    input  logic [CFG_W-1:0]       cfg_wdata_i,
    output logic [CFG_W-1:0]       cfg_rdata_o,
    output logic [N_MST-1:0]       gnt_o
);

    typedef struct packed {
        logic [N_MST-1:0] gnt;
        logic [IDX_W-1:0] ptr;
    } arb_state_t;

    arb_state_t       st_d, st_q;
    arb_cfg_t         cfg;
    logic             start_load;
    logic             fix_vld, rr_vld, pick_vld;
    logic [IDX_W-1:0] fix_idx, rr_idx, pick_idx;
    logic             holding;

    function automatic logic [IDX_W-1:0] after_idx(input logic [IDX_W-1:0] i);
        if (int'(i) == N_MST - 1) return '0;
        return i + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] start_to_ptr(input logic [START_W-1:0] s);
        return IDX_W'(int'(s) % N_MST);
    endfunction

    arb_cfg_reg u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (cfg_we_i),
        .wdata_i      (cfg_wdata_i),
        .cfg_o        (cfg),
        .start_load_o (start_load),
        .rdata_o      (cfg_rdata_o)
    );

    arb_fixed_pick #(.N_MST(N_MST)) u_fix (
        .req_i (req_i),
        .lvl_i (lvl_i),
        .vld_o (fix_vld),
        .idx_o (fix_idx)
    );

    arb_rr_pick #(.N_MST(N_MST)) u_rr (
        .req_i (req_i),
        .ptr_i (st_q.ptr),
        .vld_o (rr_vld),
        .idx_o (rr_idx)
    );

    assign pick_vld = cfg.rr ? rr_vld : fix_vld;
    assign pick_idx = cfg.rr ? rr_idx : fix_idx;
    assign holding  = |(st_q.gnt & req_i);

    always_comb begin
        st_d = st_q;
        if (!holding) begin
            st_d.gnt = '0;
            if (pick_vld) begin
                st_d.gnt[pick_idx] = 1'b1;
                if (cfg.rr) begin
                    st_d.ptr = after_idx(pick_idx);
                end
            end
        end
        // A written starting level overrides the advance of the same cycle.
        if (start_load) begin
            st_d.ptr = start_to_ptr(cfg_wdata_i[START_MSB:START_LSB]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;

endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
#(
    parameter int N_MST = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_MST-1:0]   req_i,
    input logic               cfg_we_i,
    input logic [CFG_W-1:0]   cfg_wdata_i,
    input logic [CFG_W-1:0]   cfg_rdata_o,
    input logic [N_MST-1:0]   gnt_o
);

    AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o)) else $error("more than one grant"); // R8

    AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == '0) |=> (gnt_o == '0)) else $error("grant without request"); // R10

    AST_CFG_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> (cfg_rdata_o[CFG_W-1:START_LSB] == $past(cfg_wdata_i[CFG_W-1:START_LSB])))
        else $error("config readback mismatch"); // R2

    for (genvar k = 0; k < N_MST; k++) begin : g_mst
        AST_HOLD_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[k] && req_i[k]) |=> gnt_o[k]) else $error("held grant lost"); // R9

        AST_GRANT_HAD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(gnt_o[k]) |-> $past(req_i[k])) else $error("grant without prior request"); // R9
    end

endmodule

bind cfg_arbiter arb_checker #(.N_MST(N_MST)) u_arb_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .gnt_o       (gnt_o)
);

// File: tb/cfg_arbiter_test.sv
`timescale 1ns/1ps
module cfg_arbiter_test;

    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*3-1:0] lvl = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  gnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_arbiter #(.N_MST(N)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .lvl_i       (lvl),
        .cfg_we_i    (we),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .gnt_o       (gnt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_gnt(input string tag, input logic [N-1:0] exp);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s grant actual %b expected %b", tag, gnt, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [31:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", tag, rdata, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        we = 1'b1;
        wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic set_lvl(input int l0, input int l1, input int l2, input int l3);
        lvl = {3'(l3), 3'(l2), 3'(l1), 3'(l0)};
    endtask

    task automatic t_reset();
        chk_gnt("R1", 4'b0000);
        chk_rd("R1", 32'h0000_0000);
    endtask

    task automatic t_fixed();
        set_lvl(5, 1, 1, 3);
        req = 4'b1111;
        tick();
        chk_gnt("R3_R4 tie at level 1", 4'b0010);
        set_lvl(0, 1, 1, 3);
        tick();
        chk_gnt("R9 hold despite better level", 4'b0010);
        req = 4'b1101;
        tick();
        chk_gnt("R9_R3 rearbitrate to level 0", 4'b0001);
        req = 4'b0000;
        tick();
        chk_gnt("R10 idle", 4'b0000);
        set_lvl(2, 2, 2, 2);
        req = 4'b1100;
        tick();
        chk_gnt("R4 lowest index on tie", 4'b0100);
        req = 4'b0000;
        tick();
    endtask

    task automatic t_fixed_ignores_start();
        wr(32'h7000_0000);
        chk_rd("R2 fixed with start 7", 32'h7000_0000);
        set_lvl(4, 4, 2, 2);
        req = 4'b1011;
        tick();
        chk_gnt("R7_R3 start 7", 4'b1000);
        req = 4'b0000;
        tick();
        wr(32'h1000_0000);
        req = 4'b1011;
        tick();
        chk_gnt("R7 start 1", 4'b1000);
        req = 4'b0000;
        tick();
    endtask

    task automatic t_low_bits();
        wr(32'h0FFF_FFFF);
        chk_rd("R11 low bits dropped", 32'h0000_0000);
        wr(32'hFFFF_FFFF);
        chk_rd("R11_R2 round robin start 7", 32'hF000_0000);
    endtask

    task automatic t_round_robin();
        req = 4'b0111;
        tick();
        chk_gnt("R6 start 7 mod 4 gives pointer 3", 4'b0001);
        req = 4'b0110;
        tick();
        chk_gnt("R5 pointer 1", 4'b0010);
        req = 4'b0101;
        tick();
        chk_gnt("R5 pointer 2", 4'b0100);
        req = 4'b0011;
        tick();
        chk_gnt("R5 wrap from pointer 3", 4'b0001);
        req = 4'b0000;
        tick();
        chk_gnt("R10 idle", 4'b0000);
        repeat (3) tick();
        req = 4'b1111;
        tick();
        chk_gnt("R10 pointer kept at 1", 4'b0010);
    endtask

    task automatic t_policy_mid_grant();
        wr(32'h0000_0000);
        chk_gnt("R12 grant survives policy write", 4'b0010);
        tick();
        chk_gnt("R12 grant still held", 4'b0010);
        set_lvl(0, 4, 2, 2);
        req = 4'b1101;
        tick();
        chk_gnt("R12_R3 fixed mode at next decision", 4'b0001);
        req = 4'b0000;
        tick();
    endtask

    task automatic t_write_meets_grant();
        wr(32'hA000_0000);
        req = 4'b1111;
        wr(32'hC000_0000);
        chk_gnt("R6 grant from old pointer 2", 4'b0100);
        req = 4'b1011;
        tick();
        chk_gnt("R6 written pointer 0 beats advance", 4'b0001);
        req = 4'b0000;
        tick();
        chk_gnt("R10 idle after test", 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_fixed_ignores_start();
        t_low_bits();
        t_round_robin();
        t_policy_mid_grant();
        t_write_meets_grant();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule